// File: doc/BRIEF.md
# Pipelined Prime-Field Multiplier with Operand Select

This block multiplies a 64-bit butterfly output by a second 64-bit operand modulo the prime p = 2^64 - 2^32 + 1, in four registered stages with one result per clock. A 2-bit mode picks the second operand. It can be a twiddle factor, the constant one, the matching butterfly output of a second transform unit, or the inverse of the transform length N. One multiplier therefore covers twiddle scaling, pass-through, pointwise products and the final 1/N scaling of an inverse transform.

The 128-bit product is reduced without a divider. The modulus gives 2^64 ≡ 2^32 - 1 and 2^96 ≡ -1. The product is cut into a low 64-bit word and two 32-bit upper pieces. These are folded with one addition and two subtractions, and at most two conditional subtractions of p follow. N^-1 is derived at elaboration from the length parameter `LOG_N`. Inputs must be below p.

Top module: `mmsel_top`

## Requirements
- R1: With mode 2'b00, the result is bfly_in × twiddle_in mod p.
- R2: With mode 2'b01, the result equals bfly_in.
- R3: With mode 2'b10, the result is bfly_in × peer_in mod p.
- R4: With mode 2'b11, the result is bfly_in × N^-1 mod p, where N = 2^LOG_N, so bfly_in = N gives 1.
- R5: out_valid is high exactly four clock edges after in_valid was sampled high, and low otherwise. Reset clears it.
- R6: Whenever out_valid is high, out_result is below p.
- R7: A new operation can be accepted on every clock. Each operation uses the mode and operands sampled in its own cycle.
- R8: Extreme operands reduce correctly: (p-1)×(p-1) gives 1, and a zero bfly_in gives 0.
- R9: Operand inputs that the current mode does not select have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| mode | input | 2 | Operand select: 00 twiddle, 01 one, 10 peer, 11 inverse N |
| bfly_in | input | 64 | Butterfly output to scale, below p |
| twiddle_in | input | 64 | Twiddle factor, below p |
| peer_in | input | 64 | Butterfly output of the second transform unit, below p |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Reduced product |

## Verification
The bench builds the block with LOG_N = 16, so N^-1 is the field element 0xFFFEFFFF00010001. Feeding bfly_in = 65536 in inverse mode therefore has to return exactly one. The bench works out N^-1 on its own by repeated doubling, using 2^192 ≡ 1 mod p. With this value and with operands near p, the fold reaches both correction steps. A back-to-back stream with the mode changing every cycle tests that the mode stays with its own operation through all four stages.

// File: rtl/mmsel_pkg.sv
// Shared constants and types for the operand-select modular multiplier.
// Assumes the fixed prime p = 2^64 - 2^32 + 1.
package mmsel_pkg;
    localparam int unsigned DW    = 64;          // field element width
    localparam int unsigned HW    = DW / 2;      // piece width for folding
    localparam int unsigned PW    = 2 * DW;      // full product width
    localparam int unsigned FW    = DW + 2;      // folded sum width (< 3p)
    localparam logic [DW-1:0] MODP = 64'hFFFF_FFFF_0000_0001;

    typedef enum logic [1:0] {
        SEL_TWIDDLE = 2'b00,
        SEL_ONE     = 2'b01,
        SEL_PEER    = 2'b10,
        SEL_NINV    = 2'b11
    } opsel_e;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
    } opnd_t;

    typedef struct packed {
        logic          vld;
        logic [PW-1:0] prod;
    } prod_t;

    typedef struct packed {
        logic          vld;
        logic [FW-1:0] fold;
    } fold_t;

    // N^-1 mod p for N = 2^log_n (log_n <= 32): p - (p-1)/N, since p-1 is a multiple of N.
    function automatic logic [DW-1:0] ninv_of(input int unsigned log_n);
        return MODP - ((MODP - 1) >> log_n);
    endfunction
endpackage

// File: rtl/mmsel_opsel.sv
// Stage 1: picks the second operand by mode and registers both operands with valid.
// Assumes all operand inputs are below p.
module mmsel_opsel
    import mmsel_pkg::*;
#(
    parameter logic [DW-1:0] NINV = 64'd1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  opsel_e        mode,
    input  logic [DW-1:0] bfly_in,
    input  logic [DW-1:0] twiddle_in,
    input  logic [DW-1:0] peer_in,
    output opnd_t         s1
);
    logic [DW-1:0] sel_b;

    // Operand multiplexer driven by the current mode.
    always_comb begin
        unique case (mode)
            SEL_TWIDDLE: sel_b = twiddle_in;
            SEL_ONE:     sel_b = DW'(1);
            SEL_PEER:    sel_b = peer_in;
            default:     sel_b = NINV;
        endcase
    end

    // Stage-1 register: both operands and valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
        end else begin
            s1.vld <= in_valid;
            s1.a   <= bfly_in;
            s1.b   <= sel_b;
        end
    end
endmodule

// File: rtl/mmsel_mul.sv
// Stage 2: full-width 64x64 product, registered with valid.
// Assumes the product of two values below p fits in 128 bits (always true).
module mmsel_mul
    import mmsel_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  opnd_t s1,
    output prod_t s2
);
    // Stage-2 register: unreduced product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2 <= '0;
        end else begin
            s2.vld  <= s1.vld;
            s2.prod <= PW'(s1.a) * PW'(s1.b);
        end
    end
endmodule

// File: rtl/mmsel_fold.sv
// Stage 3: folds the 128-bit product into a value below 3p using
// 2^64 = 2^32 - 1 and 2^96 = -1 (mod p); p is added to keep the sum non-negative.
module mmsel_fold
    import mmsel_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  prod_t s2,
    output fold_t s3
);
    logic [DW-1:0] lo;
    logic [HW-1:0] mid;
    logic [HW-1:0] hi;
    logic [FW-1:0] mid_term;
    logic [FW-1:0] hi_term;
    logic [FW-1:0] sum;

    // Split the product and form lo + mid*(2^32-1) + (p - hi).
    always_comb begin
        lo       = s2.prod[DW-1:0];
        mid      = s2.prod[DW+HW-1:DW];
        hi       = s2.prod[PW-1:DW+HW];
        mid_term = (FW'(mid) << HW) - FW'(mid);
        hi_term  = FW'(MODP) - FW'(hi);
        sum      = FW'(lo) + mid_term + hi_term;
    end

    // Stage-3 register: folded sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3 <= '0;
        end else begin
            s3.vld  <= s2.vld;
            s3.fold <= sum;
        end
    end
endmodule

// File: rtl/mmsel_corr.sv
// Stage 4: brings a folded value below 3p into [0, p) by subtracting 0, p or 2p.
// Assumes the input is below 3p, which the fold stage guarantees.
module mmsel_corr
    import mmsel_pkg::*;
#(
    parameter int unsigned NCAND = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fold_t         s3,
    output logic          out_valid,
    output logic [DW-1:0] out_result
);
    logic [FW-1:0] cand [NCAND];
    logic [NCAND-1:0] fits;
    logic [DW-1:0] pick;

    // One candidate per multiple of p, with its range test.
    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        localparam logic [FW-1:0] KP = FW'(k) * FW'(MODP);
        assign fits[k] = (s3.fold >= KP);
        assign cand[k] = s3.fold - KP;
    end

    // Take the largest multiple of p not exceeding the folded value.
    always_comb begin
        pick = cand[0][DW-1:0];
        for (int k = 1; k < NCAND; k++) begin
            if (fits[k]) pick = cand[k][DW-1:0];
        end
    end

    // Stage-4 register: final result and valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid  <= s3.vld;
            out_result <= pick;
        end
    end
endmodule

// File: rtl/mmsel_top.sv
// Four-stage modular multiplier over p = 2^64 - 2^32 + 1 with a four-way
// second-operand select. Throughput one per clock, latency four.
// Assumes LOG_N <= 32 and every operand input below p.
module mmsel_top
    import mmsel_pkg::*;
#(
    parameter int unsigned LOG_N = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    mode,
    input  logic [63:0]   bfly_in,
    input  logic [63:0]   twiddle_in,
    input  logic [63:0]   peer_in,
    output logic          out_valid,
    output logic [63:0]   out_result
);
    localparam logic [DW-1:0] NINV = ninv_of(LOG_N);

    opnd_t  s1;
    prod_t  s2;
    fold_t  s3;
    opsel_e mode_e;

    // Map the plain port onto the mode type.
    assign mode_e = opsel_e'(mode);

    mmsel_opsel #(.NINV(NINV)) u_opsel (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .mode       (mode_e),
        .bfly_in    (bfly_in),
        .twiddle_in (twiddle_in),
        .peer_in    (peer_in),
        .s1         (s1)
    );

    mmsel_mul u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .s1    (s1),
        .s2    (s2)
    );

    mmsel_fold u_fold (
        .clk   (clk),
        .rst_n (rst_n),
        .s2    (s2),
        .s3    (s3)
    );

    mmsel_corr #(.NCAND(3)) u_corr (
        .clk        (clk),
        .rst_n      (rst_n),
        .s3         (s3),
        .out_valid  (out_valid),
        .out_result (out_result)
    );
endmodule

// File: rtl/mmsel_chk.sv
// Port-level assertions for mmsel_top, attached by bind.
module mmsel_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  mode,
    input logic [63:0] bfly_in,
    input logic [63:0] out_result,
    input logic        out_valid
);
    localparam logic [63:0] P = 64'hFFFF_FFFF_0000_0001;
    logic [2:0] since_rst;
    logic       warm;

    // Count cycles since reset so history checks only look at driven values.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
    end
    assign warm = (since_rst == 3'd4);

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> !out_valid); // R5
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 4))); // R5
    AST_RESULT_BELOW_P: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_result < P)); // R6
    AST_ONE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid, 4) && $past(mode, 4) == 2'b01)
        |-> (out_result == $past(bfly_in, 4))); // R2
    AST_ZERO_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid, 4) && $past(bfly_in, 4) == 64'd0)
        |-> (out_result == 64'd0)); // R8
endmodule

bind mmsel_top mmsel_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .mode       (mode),
    .bfly_in    (bfly_in),
    .out_result (out_result),
    .out_valid  (out_valid)
);

// File: tb/mmsel_top_tb.sv
`timescale 1ns/1ps
module mmsel_top_tb;
    localparam int unsigned LOGN = 16;
    localparam logic [63:0] P = 64'hFFFF_FFFF_0000_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [63:0] bfly_in = '0, twiddle_in = '0, peer_in = '0;
    logic        out_valid;
    logic [63:0] out_result;
    int n_chk = 0, n_bad = 0;
    logic [63:0] ninv_ref;

    always #2 clk = ~clk;

    mmsel_top #(.LOG_N(LOGN)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .bfly_in(bfly_in), .twiddle_in(twiddle_in), .peer_in(peer_in),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [63:0] refmul(input logic [63:0] a, input logic [63:0] b);
        logic [127:0] w;
        w = {64'd0, a} * {64'd0, b};
        return 64'(w % {64'd0, P});
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation and check the latency window and the result.
    task automatic run_one(input string req, input logic [1:0] m, input logic [63:0] a,
                           input logic [63:0] tw, input logic [63:0] pr, input logic [63:0] exp);
        @(negedge clk);
        in_valid = 1'b1; mode = m; bfly_in = a; twiddle_in = tw; peer_in = pr;
        @(negedge clk);
        in_valid = 1'b0; mode = ~m; bfly_in = ~a; twiddle_in = ~tw; peer_in = ~pr;
        @(negedge clk);
        @(negedge clk);
        chk("R5 early", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        chk("R5 on time", {63'd0, out_valid}, 64'd1);
        chk(req, out_result, exp);
        chk("R6", {63'd0, out_result < P}, 64'd1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R5 reset", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_twiddle();
        run_one("R1 mix", 2'b00, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'd7,
                refmul(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321));
        run_one("R1 high", 2'b00, P - 64'd2, 64'hFFFF_FFFF_0000_0000, 64'd0,
                refmul(P - 64'd2, 64'hFFFF_FFFF_0000_0000));
    endtask

    task automatic t_one();
        run_one("R2 R9 one", 2'b01, 64'hDEAD_BEEF_0BAD_F00D, 64'h5555, 64'hAAAA, 64'hDEAD_BEEF_0BAD_F00D);
        run_one("R2 R9 one alt", 2'b01, 64'hDEAD_BEEF_0BAD_F00D, 64'h1, 64'h2, 64'hDEAD_BEEF_0BAD_F00D);
    endtask

    task automatic t_peer();
        run_one("R3 peer", 2'b10, 64'h0000_0001_0000_0000, 64'h99, 64'h0000_0001_0000_0000,
                refmul(64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000));
        run_one("R3 R9 peer", 2'b10, 64'hCAFE_0000_1234_5678, 64'h3, 64'h8765_4321_0FED_CBA9,
                refmul(64'hCAFE_0000_1234_5678, 64'h8765_4321_0FED_CBA9));
    endtask

    task automatic t_ninv();
        run_one("R4 N*Ninv", 2'b11, 64'd1 << LOGN, 64'h77, 64'h88, 64'd1);
        run_one("R4 scale", 2'b11, 64'h0123_4567_89AB_CDEF, 64'h0, 64'h0,
                refmul(64'h0123_4567_89AB_CDEF, ninv_ref));
    endtask

    task automatic t_extreme();
        run_one("R8 max", 2'b00, P - 64'd1, P - 64'd1, 64'd0, 64'd1);
        run_one("R8 zero", 2'b10, 64'd0, 64'd5, P - 64'd1, 64'd0);
    endtask

    // Back-to-back stream with the mode changing every cycle.
    task automatic t_stream();
        logic [63:0] exp_q [6];
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (c >= 4) begin
                chk("R7 valid", {63'd0, out_valid}, 64'd1);
                chk("R7 data", out_result, exp_q[c-4]);
            end
            if (c < 6) begin
                logic [63:0] a, tw, pr;
                a  = (64'h9E37_79B9_7F4A_7C15 * 64'(c + 1)) % P;
                tw = (64'hC2B2_AE3D_27D4_EB4F * 64'(c + 3)) % P;
                pr = (64'h1656_67B1_9E37_79F9 * 64'(c + 5)) % P;
                in_valid = 1'b1; mode = 2'(c); bfly_in = a; twiddle_in = tw; peer_in = pr;
                case (2'(c))
                    2'b00: exp_q[c] = refmul(a, tw);
                    2'b01: exp_q[c] = a;
                    2'b10: exp_q[c] = refmul(a, pr);
                    default: exp_q[c] = refmul(a, ninv_ref);
                endcase
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk("R5 drain", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        ninv_ref = 64'd1;
        for (int i = 0; i < 192 - LOGN; i++) ninv_ref = refmul(ninv_ref, 64'd2);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_twiddle();
        t_one();
        t_peer();
        t_ninv();
        t_extreme();
        t_stream();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule